// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Receive Queue

This block takes an asynchronous serial line carrying 8-bit characters (one start bit, eight data bits sent least significant first, no parity, one stop bit) and turns each good character into a byte held in a 16-entry on-block queue. Timing comes from an enable pulse supplied from outside at sixteen times the bit rate. The receiver advances only on clock cycles where that pulse is high, so the same block serves any bit rate the surrounding logic can produce.

The consumer reads the oldest byte from a parallel output. A one-cycle read strobe removes it, and the next byte appears. Three flags tell the consumer whether anything is waiting, whether at least half of the queue is occupied, and whether it is completely occupied. A separate synchronous clear empties the queue without disturbing a character that is being received at that moment.

Top module: `uart_rx_fifo_top`

## Requirements
- R1: A falling edge on the line starts a character only if the line is still low 8 enable pulses after the edge is first seen; a shorter low pulse produces no byte.
- R2: After a confirmed start, each data bit is sampled 16 enable pulses after the previous sample, least significant bit first, and the assembled byte is queued when the stop bit samples high.
- R3: A character whose stop bit samples low is discarded and leaves the queue unchanged.
- R4: Receiver timing advances only on clock cycles where the 16x enable is high; pausing the enable stretches a character without corrupting it.
- R5: The queue holds up to 16 bytes and returns them in arrival order on `rd_data`, which shows the oldest byte whenever the queue is not empty.
- R6: `data_avail` is high exactly when the queue holds at least one byte.
- R7: `half_full` is high exactly when the queue holds 8 or more bytes.
- R8: `full` is high exactly when the queue holds 16 bytes.
- R9: A byte completed while the queue is full is dropped; the stored bytes and their order are unchanged.
- R10: A one-cycle `rd_strobe` removes the oldest byte; a strobe on an empty queue has no effect.
- R11: `buf_clear` empties the queue in one clock without affecting a character in progress, which is still queued when it completes.
- R12: While reset is asserted the queue is empty and all three flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_x16_en | input | 1 | Enable pulse at 16 times the bit rate |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| rd_strobe | input | 1 | Removes the oldest queued byte |
| buf_clear | input | 1 | Synchronous queue clear |
| rd_data | output | 8 | Oldest queued byte |
| data_avail | output | 1 | Queue not empty |
| half_full | output | 1 | Queue holds 8 or more bytes |
| full | output | 1 | Queue holds 16 bytes |

## Verification
The hardest situation to reach is a queue clear landing in the middle of a character, since it has to meet a receiver that is partway through its bit samples and a queue that already holds older bytes. The stimulus forks a clear into the data-bit phase of a frame sent on top of a partly filled queue and expects only that frame's byte afterwards. The other hard case, a character completing into a full queue, is reached by sending seventeen frames back to back and then draining all sixteen survivors in order.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line,
  output logic                 push,
  output logic [DATA_BITS-1:0] byte_out
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] MID_CNT  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OVERSAMPLE - 1);
  localparam logic [IW-1:0] LAST_BIT = IW'(DATA_BITS - 1);

  rx_state_t            st_q, st_n;
  logic [CW-1:0]        cnt_q, cnt_n;
  logic [IW-1:0]        idx_q, idx_n;
  logic [DATA_BITS-1:0] sh_q, sh_n;
  logic                 push_q, push_n;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    push_n = 1'b0;
    if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          if (!line) begin
            st_n  = RX_START;
            cnt_n = '0;
          end
        end
        RX_START: begin
          if (cnt_q == MID_CNT) begin
            cnt_n = '0;
            idx_n = '0;
            st_n  = line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == LAST_CNT) begin
            cnt_n = '0;
            sh_n  = {line, sh_q[DATA_BITS-1:1]};
            if (idx_q == LAST_BIT) st_n = RX_STOP;
            else                   idx_n = idx_q + 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == LAST_CNT) begin
            cnt_n  = '0;
            st_n   = RX_IDLE;
            push_n = line;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      push_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      push_q <= push_n;
    end
  end

  assign push     = push_q;
  assign byte_out = sh_q;

  AST_STATE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(st_q) && $stable(cnt_q)); // R4
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |=> !push_q); // R2
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> $past(line) && $past(tick)); // R3
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] rdata,
  output logic             not_empty,
  output logic             half,
  output logic             is_full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_CNT = (AW+1)'(DEPTH / 2);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_n, rp_q, rp_n;
  logic [AW:0]      cnt_q, cnt_n;
  logic             do_wr, do_rd;

  assign do_wr = wr && (cnt_q != FULL_CNT) && !clr;
  assign do_rd = rd && (cnt_q != '0) && !clr;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (clr) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_wr) wp_n = wp_q + 1'b1;
      if (do_rd) rp_n = rp_q + 1'b1;
      if (do_wr && !do_rd)      cnt_n = cnt_q + 1'b1;
      else if (do_rd && !do_wr) cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wdata;
  end

  assign rdata     = mem[rp_q];
  assign not_empty = (cnt_q != '0);
  assign half      = (cnt_q >= HALF_CNT);
  assign is_full   = (cnt_q == FULL_CNT);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    is_full && wr && !rd && !clr |=> is_full && $stable(wp_q) && $stable(rp_q)); // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !not_empty); // R11
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !not_empty && rd && !wr |=> !not_empty && $stable(rp_q)); // R10
  AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    is_full |-> half && not_empty); // R8
endmodule

// File: rtl/uart_rx_fifo_top.sv
module uart_rx_fifo_top #(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_x16_en,
  input  logic                 rx_serial,
  input  logic                 rd_strobe,
  input  logic                 buf_clear,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 data_avail,
  output logic                 half_full,
  output logic                 full
);
  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic                 line_s;
  logic                 push;
  logic [DATA_BITS-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  (rx_serial),
    .dout (line_s)
  );

  uart_rx_deser #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_deser (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (baud_x16_en),
    .line    (line_s),
    .push    (push),
    .byte_out(rx_byte)
  );

  uart_rx_fifo #(.WIDTH(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (buf_clear),
    .wr       (push),
    .wdata    (rx_byte),
    .rd       (rd_strobe),
    .rdata    (rd_data),
    .not_empty(data_avail),
    .half     (half_full),
    .is_full  (full)
  );

  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_int_n |-> !data_avail && !half_full && !full); // R12
endmodule

// File: tb/uart_rx_fifo_top_tb_top.sv
module uart_rx_fifo_top_tb_top;
  logic       clk;
  logic       rst_n;
  logic       en16;
  logic       rx;
  logic       rd;
  logic       clr;
  logic [7:0] rd_data;
  logic       data_avail, half_full, full;

  logic [7:0] q[$];
  int  checks;
  int  errors;
  bit  cmp_en;
  bit  tick_run;
  bit  done;
  int  div;

  uart_rx_fifo_top dut_i (
    .clk(clk), .rst_n(rst_n), .baud_x16_en(en16), .rx_serial(rx),
    .rd_strobe(rd), .buf_clear(clr), .rd_data(rd_data),
    .data_avail(data_avail), .half_full(half_full), .full(full)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  initial begin
    en16 = 1'b0;
    div  = 0;
    forever begin
      @(negedge clk);
      if (tick_run) begin
        div  = (div + 1) % 4;
        en16 = (div == 0);
      end else begin
        en16 = 1'b0;
      end
    end
  end

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    check_bit({tag, " R6 data_avail"}, data_avail, q.size() != 0);
    check_bit({tag, " R7 half_full"}, half_full, q.size() >= 8);
    check_bit({tag, " R8 full"}, full, q.size() == 16);
    if (q.size() != 0) begin
      checks++;
      if (rd_data !== q[0]) begin
        errors++;
        $display("FAIL %s R5 rd_data: actual=%02h expected=%02h at %0t", tag, rd_data, q[0], $time);
      end
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n && !done) compare("cycle");
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!en16) @(posedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input bit good);
    wait_ticks(1);
    @(negedge clk) rx = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) rx = b[i];
      wait_ticks(16);
    end
    cmp_en = 1'b0;
    @(negedge clk) rx = good;
    wait_ticks(16);
    @(negedge clk) rx = 1'b1;
    if (good && q.size() < 16) q.push_back(b);
    cmp_en = 1'b1;
    wait_ticks(16);
  endtask

  task automatic read_one();
    @(negedge clk) rd = 1'b1;
    @(posedge clk);
    if (q.size() != 0) void'(q.pop_front());
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic clear_buf();
    @(negedge clk) clr = 1'b1;
    @(posedge clk);
    q.delete();
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; cmp_en = 1'b0; tick_run = 1'b1; done = 1'b0;
    rst_n = 1'b0; rx = 1'b1; rd = 1'b0; clr = 1'b0;
    repeat (4) @(negedge clk);
    // R12: flags low during reset
    check_bit("R12 data_avail", data_avail, 1'b0);
    check_bit("R12 half_full", half_full, 1'b0);
    check_bit("R12 full", full, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;

    // R2 / R5: three frames, distinct bit patterns
    send_frame(8'hA5, 1'b1);
    send_frame(8'h3C, 1'b1);
    send_frame(8'h01, 1'b1);
    compare("R2 after three frames");
    // R10: pop in order
    read_one(); compare("R10 pop1");
    read_one(); compare("R10 pop2");
    read_one(); compare("R10 pop3");
    read_one(); compare("R10 pop on empty");

    // R1: short low glitch gives no byte
    wait_ticks(1);
    @(negedge clk) rx = 1'b0;
    wait_ticks(3);
    @(negedge clk) rx = 1'b1;
    wait_ticks(40);
    compare("R1 glitch rejected");

    // R3: bad stop bit discarded
    send_frame(8'h5A, 1'b1);
    send_frame(8'hFF, 1'b0);
    wait_ticks(20);
    compare("R3 framing error");
    send_frame(8'h80, 1'b1);
    compare("R3 next frame ok");

    // R4: enable paused mid-frame
    fork
      send_frame(8'hC3, 1'b1);
      begin
        wait_ticks(60);
        tick_run = 1'b0;
        repeat (300) @(negedge clk);
        tick_run = 1'b1;
      end
    join
    compare("R4 paused enable");

    // R11: clear between frames
    clear_buf();
    compare("R11 clear idle");

    // R7 / R8 / R9: fill to 16, overflow drops 17th
    for (int k = 0; k < 17; k++) begin
      send_frame(8'(8'h10 + k * 7), 1'b1);
      if (k == 7) compare("R7 eight bytes");
    end
    compare("R9 overflow dropped");
    for (int k = 0; k < 16; k++) read_one();
    compare("R9 drained");

    // R11: clear during a frame in progress keeps that frame
    send_frame(8'h11, 1'b1);
    send_frame(8'h22, 1'b1);
    fork
      send_frame(8'h96, 1'b1);
      begin
        wait_ticks(60);
        clear_buf();
      end
    join
    compare("R11 clear mid-frame");
    checks++;
    if (q.size() != 1) begin
      errors++;
      $display("FAIL R11 model depth: actual=%0d expected=1", q.size());
    end
    read_one(); compare("R11 after pop");

    finish_run();
  end
endmodule